// File: doc/BRIEF.md
# Fetch Translation and Line Reuse Filter

This block sits in front of the instruction translation buffer and the instruction tag array. It holds two registers. The first holds the virtual page number and physical page number of the last translated fetch. The second holds the identity of the last cache line that was looked up. A fetch whose virtual page equals the held page does not raise the translation strobe, because the held physical page is already known. A fetch that also lands on the held line raises neither strobe. Both lookups are skipped, and the block saves their latency and their energy.

Pages are 16 KiB, so the low 14 address bits go to the physical address unchanged. On a page miss the block sends one request on its translation port and stalls further fetches until the response arrives. It then drives the tag lookup and delivers the physical address. Invalidation inputs keep the held identities coherent: one for a context switch, one for a translation invalidate and one for a cache line invalidate. Two wrapping counters report how many translation lookups and how many tag lookups were skipped.

Top module: `fxr_fetch_filter`

## Requirements
- R1: After reset, fetch_ready is 1, out_valid is 0, both skip counters are 0, and both held identities are invalid, so the first fetch always requests a translation.
- R2: A fetch accepted on a page miss raises tlb_req in its acceptance cycle, with tlb_vpn equal to fetch_va[47:14]. tag_en stays low in that cycle. fetch_ready is then 0 until the cycle in which tlb_rsp_valid is seen. In that cycle tag_en is 1 and tag_line is {tlb_rsp_ppn, va[13:6]}. One cycle later out_valid is 1, out_pa is {tlb_rsp_ppn, va[13:0]}, and both reuse flags are 0.
- R3: A fetch to the held page but a different line does not raise tlb_req. It raises tag_en in its acceptance cycle, with tag_line {held ppn, va[13:6]}. One cycle later it delivers out_pa = {held ppn, va[13:0]}, with out_page_reuse 1 and out_line_reuse 0.
- R4: A fetch to the held line raises neither tlb_req nor tag_en. One cycle later it delivers the physical address with out_page_reuse and out_line_reuse both 1.
- R5: Fetches that hit the held page are accepted in consecutive cycles, and each one produces its output one cycle after acceptance.
- R6: Bits 13:0 of out_pa always equal bits 13:0 of the fetch address. The page is 16 KiB.
- R7: inv_ctx or inv_tlb clears both held identities. A fetch accepted in the same cycle is handled as a page miss.
- R8: inv_line clears only the held line. A later fetch to the same line reuses the page (no tlb_req) but raises tag_en.
- R9: If inv_ctx or inv_tlb arrives while a translation is outstanding, the response is still delivered at the output but is not kept. The next fetch to that page requests a translation again.
- R10: skip_tlb_cnt increments once for each fetch that reuses the page. skip_tag_cnt increments once for each fetch that reuses the line. Both wrap modulo 2^CNT_W.
- R11: In a cycle with fetch_valid low while idle, neither strobe is raised and no output follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch address is present |
| fetch_va | input | VA_W | Fetch virtual address |
| fetch_ready | output | 1 | Block can accept a fetch this cycle |
| inv_ctx | input | 1 | Context switch: drop held page and line |
| inv_tlb | input | 1 | Translation invalidate: drop held page and line |
| inv_line | input | 1 | Cache line invalidate: drop held line |
| tlb_req | output | 1 | Translation lookup strobe |
| tlb_vpn | output | VA_W-14 | Virtual page number to translate |
| tlb_rsp_valid | input | 1 | Translation response present |
| tlb_rsp_ppn | input | PA_W-14 | Translated physical page number |
| tag_en | output | 1 | Tag array lookup strobe |
| tag_line | output | PA_W-LINE_OFF_W | Physical line address for the tag lookup |
| out_valid | output | 1 | Physical fetch address valid |
| out_pa | output | PA_W | Physical fetch address |
| out_page_reuse | output | 1 | Translation came from the held page |
| out_line_reuse | output | 1 | Tag lookup was skipped for the held line |
| skip_tlb_cnt | output | CNT_W | Count of skipped translation lookups |
| skip_tag_cnt | output | CNT_W | Count of skipped tag lookups |

## Verification
The hardest case to reach from the ports is a translation-type invalidation that arrives while a translation is still outstanding. The address must be delivered, yet the page must not be kept. To reach it, the stimulus stretches the response delay over one to three cycles and pulses inv_tlb in the first waiting cycle. A later fetch to the same page then shows whether a fresh request is raised. The random phase draws addresses from four pages and four lines per page, so reuse of the page and of the line happens often. It mixes in rare invalidations that also coincide with accepted fetches. A narrowed counter width lets a directed run of line hits cross the wrap point.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
    typedef enum logic {
        FXR_IDLE = 1'b0,
        FXR_WAIT = 1'b1
    } fxr_state_e;

    localparam int FXR_NUM_CNT  = 2;
    localparam int FXR_CNT_PAGE = 0;
    localparam int FXR_CNT_LINE = 1;
endpackage

// File: rtl/fxr_page_store.sv
// Held translation: virtual page, physical page and a valid bit.
module fxr_page_store #(
    parameter int VPN_W = 34,
    parameter int PPN_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [VPN_W-1:0] load_vpn_i,
    input  logic [PPN_W-1:0] load_ppn_i,
    input  logic [VPN_W-1:0] probe_vpn_i,
    output logic             hit_o,
    output logic [PPN_W-1:0] ppn_o
);
    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        // a fresh translation has priority over a concurrent clear
        if (load_i) begin
            pg_d.vld = 1'b1;
            pg_d.vpn = load_vpn_i;
            pg_d.ppn = load_ppn_i;
        end else if (clr_i) begin
            pg_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign hit_o = pg_q.vld && (pg_q.vpn == probe_vpn_i);
    assign ppn_o = pg_q.ppn;
endmodule

// File: rtl/fxr_line_store.sv
// Held line identity (virtual line number) with a valid bit.
module fxr_line_store #(
    parameter int LID_W = 42
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [LID_W-1:0] load_id_i,
    input  logic [LID_W-1:0] probe_id_i,
    output logic             hit_o
);
    typedef struct packed {
        logic             vld;
        logic [LID_W-1:0] id;
    } ln_t;

    ln_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        // a real tag lookup this cycle makes the line fresh again
        if (load_i) begin
            ln_d.vld = 1'b1;
            ln_d.id  = load_id_i;
        end else if (clr_i) begin
            ln_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign hit_o = ln_q.vld && (ln_q.id == probe_id_i);
endmodule

// File: rtl/fxr_skip_cnt.sv
// Wrapping event counter for skipped lookups.
module fxr_skip_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/fxr_fetch_filter.sv
module fxr_fetch_filter
    import fxr_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PA_W       = 40,
    parameter int PG_OFF_W   = 14,
    parameter int LINE_OFF_W = 6,
    parameter int CNT_W      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fetch_valid,
    input  logic [VA_W-1:0]            fetch_va,
    output logic                       fetch_ready,
    input  logic                       inv_ctx,
    input  logic                       inv_tlb,
    input  logic                       inv_line,
    output logic                       tlb_req,
    output logic [VA_W-PG_OFF_W-1:0]   tlb_vpn,
    input  logic                       tlb_rsp_valid,
    input  logic [PA_W-PG_OFF_W-1:0]   tlb_rsp_ppn,
    output logic                       tag_en,
    output logic [PA_W-LINE_OFF_W-1:0] tag_line,
    output logic                       out_valid,
    output logic [PA_W-1:0]            out_pa,
    output logic                       out_page_reuse,
    output logic                       out_line_reuse,
    output logic [CNT_W-1:0]           skip_tlb_cnt,
    output logic [CNT_W-1:0]           skip_tag_cnt
);
    localparam int VPN_W = VA_W - PG_OFF_W;
    localparam int PPN_W = PA_W - PG_OFF_W;
    localparam int LID_W = VA_W - LINE_OFF_W;
    localparam int IDX_W = PG_OFF_W - LINE_OFF_W;

    typedef struct packed {
        fxr_state_e      st;
        logic            drop;
        logic [VA_W-1:0] pend_va;
        logic            ovld;
        logic [PA_W-1:0] opa;
        logic            opr;
        logic            olr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             inv_page, inv_any;
    logic             pg_hit_raw, ln_hit_raw, page_hit, line_hit;
    logic [PPN_W-1:0] held_ppn;
    logic             page_load, line_load;
    logic [LID_W-1:0] line_id_sel;
    logic [PPN_W-1:0] ppn_sel;
    logic [IDX_W-1:0] idx_sel;
    logic [FXR_NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_w [FXR_NUM_CNT];

    assign inv_page = inv_ctx | inv_tlb;
    assign inv_any  = inv_page | inv_line;

    fxr_page_store #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_page (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (inv_page),
        .load_i      (page_load),
        .load_vpn_i  (ctl_q.pend_va[VA_W-1:PG_OFF_W]),
        .load_ppn_i  (tlb_rsp_ppn),
        .probe_vpn_i (fetch_va[VA_W-1:PG_OFF_W]),
        .hit_o       (pg_hit_raw),
        .ppn_o       (held_ppn)
    );

    fxr_line_store #(.LID_W(LID_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (inv_any),
        .load_i     (line_load),
        .load_id_i  (line_id_sel),
        .probe_id_i (fetch_va[VA_W-1:LINE_OFF_W]),
        .hit_o      (ln_hit_raw)
    );

    // an invalidation in the same cycle overrides any match
    assign page_hit = pg_hit_raw && !inv_page;
    assign line_hit = ln_hit_raw && !inv_any && page_hit;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ovld  = 1'b0;
        ctl_d.opr   = 1'b0;
        ctl_d.olr   = 1'b0;
        tlb_req     = 1'b0;
        tag_en      = 1'b0;
        page_load   = 1'b0;
        line_load   = 1'b0;
        inc_vec     = '0;
        line_id_sel = fetch_va[VA_W-1:LINE_OFF_W];
        ppn_sel     = held_ppn;
        idx_sel     = fetch_va[PG_OFF_W-1:LINE_OFF_W];
        unique case (ctl_q.st)
            FXR_IDLE: begin
                if (fetch_valid) begin
                    if (page_hit) begin
                        ctl_d.ovld = 1'b1;
                        ctl_d.opa  = {held_ppn, fetch_va[PG_OFF_W-1:0]};
                        ctl_d.opr  = 1'b1;
                        inc_vec[FXR_CNT_PAGE] = 1'b1;
                        if (line_hit) begin
                            ctl_d.olr = 1'b1;
                            inc_vec[FXR_CNT_LINE] = 1'b1;
                        end else begin
                            tag_en    = 1'b1;
                            line_load = 1'b1;
                        end
                    end else begin
                        tlb_req       = 1'b1;
                        ctl_d.st      = FXR_WAIT;
                        ctl_d.pend_va = fetch_va;
                        ctl_d.drop    = 1'b0;
                    end
                end
            end
            FXR_WAIT: begin
                line_id_sel = ctl_q.pend_va[VA_W-1:LINE_OFF_W];
                idx_sel     = ctl_q.pend_va[PG_OFF_W-1:LINE_OFF_W];
                ppn_sel     = tlb_rsp_ppn;
                if (inv_page) ctl_d.drop = 1'b1;
                if (tlb_rsp_valid) begin
                    ctl_d.ovld = 1'b1;
                    ctl_d.opa  = {tlb_rsp_ppn, ctl_q.pend_va[PG_OFF_W-1:0]};
                    tag_en     = 1'b1;
                    page_load  = !(ctl_q.drop || inv_page);
                    line_load  = !(ctl_q.drop || inv_page);
                    ctl_d.st   = FXR_IDLE;
                    ctl_d.drop = 1'b0;
                end
            end
            default: ctl_d.st = FXR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < FXR_NUM_CNT; g++) begin : g_cnt
        fxr_skip_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc_vec[g]),
            .cnt_o (cnt_w[g])
        );
    end

    assign fetch_ready    = (ctl_q.st == FXR_IDLE);
    assign tlb_vpn        = fetch_va[VA_W-1:PG_OFF_W];
    assign tag_line       = {ppn_sel, idx_sel};
    assign out_valid      = ctl_q.ovld;
    assign out_pa         = ctl_q.opa;
    assign out_page_reuse = ctl_q.opr;
    assign out_line_reuse = ctl_q.olr;
    assign skip_tlb_cnt   = cnt_w[FXR_CNT_PAGE];
    assign skip_tag_cnt   = cnt_w[FXR_CNT_LINE];

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req |=> !fetch_ready); // R2
    AST_RSP_YIELDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_ready && tlb_rsp_valid) |=> (out_valid && !out_page_reuse && !out_line_reuse)); // R2
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tlb_req && tag_en)); // R2
    AST_PAGE_REUSE_NO_TLB: assert property (@(posedge clk) disable iff (!rst_n)
        out_page_reuse |-> $past(!tlb_req && fetch_ready)); // R3
    AST_LINE_REUSE_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_line_reuse |-> ($past(!tag_en) && out_page_reuse)); // R4
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && fetch_valid && page_hit) |=> (out_pa[PG_OFF_W-1:0] == $past(fetch_va[PG_OFF_W-1:0]))); // R6
    AST_CNT_TRACKS_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_page_reuse |-> (skip_tlb_cnt == CNT_W'($past(skip_tlb_cnt) + 1'b1))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && !fetch_valid) |-> (!tlb_req && !tag_en)); // R11
endmodule

// File: tb/fxr_fetch_filter_tb.sv
`timescale 1ns/1ps
module fxr_fetch_filter_tb;
    localparam int VA_W = 48, PA_W = 40, PG = 14, LO = 6, CNT_W = 4;
    localparam int VPN_W = VA_W - PG, PPN_W = PA_W - PG, LID_W = VA_W - LO;

    logic clk = 0, rst_n = 0;
    logic fetch_valid = 0, inv_ctx = 0, inv_tlb = 0, inv_line = 0, tlb_rsp_valid = 0;
    logic [VA_W-1:0] fetch_va = '0;
    logic [PPN_W-1:0] tlb_rsp_ppn = '0;
    logic fetch_ready, tlb_req, tag_en, out_valid, out_page_reuse, out_line_reuse;
    logic [VPN_W-1:0] tlb_vpn;
    logic [PA_W-LO-1:0] tag_line;
    logic [PA_W-1:0] out_pa;
    logic [CNT_W-1:0] skip_tlb_cnt, skip_tag_cnt;

    always #4 clk = ~clk;

    fxr_fetch_filter #(.VA_W(VA_W), .PA_W(PA_W), .PG_OFF_W(PG), .LINE_OFF_W(LO), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_va(fetch_va),
        .fetch_ready(fetch_ready), .inv_ctx(inv_ctx), .inv_tlb(inv_tlb), .inv_line(inv_line),
        .tlb_req(tlb_req), .tlb_vpn(tlb_vpn), .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_ppn(tlb_rsp_ppn),
        .tag_en(tag_en), .tag_line(tag_line), .out_valid(out_valid), .out_pa(out_pa),
        .out_page_reuse(out_page_reuse), .out_line_reuse(out_line_reuse),
        .skip_tlb_cnt(skip_tlb_cnt), .skip_tag_cnt(skip_tag_cnt));

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench reference state
    bit m_pv = 0, m_lv = 0;
    logic [VPN_W-1:0] m_vpn = '0;
    logic [PPN_W-1:0] m_ppn = '0;
    logic [LID_W-1:0] m_lid = '0;
    int m_ctlb = 0, m_ctag = 0;

    function automatic logic [PPN_W-1:0] ppn_of(input logic [VPN_W-1:0] v);
        return PPN_W'(v * 5 + 34'h1234) ^ PPN_W'(26'h2A5A5A5);
    endfunction

    function automatic logic [VA_W-1:0] mk_va(input int pg, input int ln, input int b);
        return {VPN_W'(34'h12340 + pg), 8'(ln), 6'(b)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_cnt();
        chk("R10 skip_tlb_cnt", 64'(skip_tlb_cnt), 64'(m_ctlb % (1 << CNT_W)));
        chk("R10 skip_tag_cnt", 64'(skip_tag_cnt), 64'(m_ctag % (1 << CNT_W)));
    endtask

    // entry and exit at a falling edge with inputs idle
    task automatic fetch(input logic [VA_W-1:0] va, input bit ictx, input bit itlb, input bit iline,
                         input int dly, input bit inv_wait);
        bit phit, lhit;
        logic [PPN_W-1:0] rp;
        if (ictx || itlb) begin m_pv = 0; m_lv = 0; end
        if (iline) m_lv = 0;
        phit = m_pv && (va[VA_W-1:PG] == m_vpn);
        lhit = phit && m_lv && (va[VA_W-1:LO] == m_lid);
        fetch_valid = 1; fetch_va = va; inv_ctx = ictx; inv_tlb = itlb; inv_line = iline;
        #1;
        chk("R5 fetch_ready idle", 64'(fetch_ready), 64'd1);
        chk(phit ? "R3 tlb_req on reuse" : "R2 tlb_req on miss", 64'(tlb_req), 64'(!phit));
        chk(lhit ? "R4 tag_en on line reuse" : "R8 tag_en", 64'(tag_en), 64'(phit && !lhit));
        if (!phit) chk("R2 tlb_vpn", 64'(tlb_vpn), 64'(va[VA_W-1:PG]));
        if (phit && !lhit) chk("R3 tag_line", 64'(tag_line), 64'({m_ppn, va[PG-1:LO]}));
        @(posedge clk); @(negedge clk);
        fetch_valid = 0; inv_ctx = 0; inv_tlb = 0; inv_line = 0;
        if (phit) begin
            m_ctlb++;
            if (lhit) m_ctag++;
            else begin m_lv = 1; m_lid = va[VA_W-1:LO]; end
            chk("R3 out_valid", 64'(out_valid), 64'd1);
            chk("R6 out_pa", 64'(out_pa), 64'({m_ppn, va[PG-1:0]}));
            chk("R3 out_page_reuse", 64'(out_page_reuse), 64'd1);
            chk("R4 out_line_reuse", 64'(out_line_reuse), 64'(lhit));
        end else begin
            rp = ppn_of(va[VA_W-1:PG]);
            chk("R2 out_valid during wait", 64'(out_valid), 64'd0);
            for (int d = 1; d <= dly; d++) begin
                if (d == 1 && inv_wait) inv_tlb = 1;
                if (d == dly) begin tlb_rsp_valid = 1; tlb_rsp_ppn = rp; end
                #1;
                chk("R2 fetch_ready stalled", 64'(fetch_ready), 64'd0);
                if (d == dly) begin
                    chk("R2 tag_en on response", 64'(tag_en), 64'd1);
                    chk("R2 tag_line on response", 64'(tag_line), 64'({rp, va[PG-1:LO]}));
                end
                @(posedge clk); @(negedge clk);
                inv_tlb = 0; tlb_rsp_valid = 0;
            end
            chk("R2 out_valid after response", 64'(out_valid), 64'd1);
            chk("R6 out_pa after response", 64'(out_pa), 64'({rp, va[PG-1:0]}));
            chk("R2 reuse flags after miss", 64'({out_page_reuse, out_line_reuse}), 64'd0);
            if (inv_wait) begin m_pv = 0; m_lv = 0; end // R9
            else begin
                m_pv = 1; m_vpn = va[VA_W-1:PG]; m_ppn = rp;
                m_lv = 1; m_lid = va[VA_W-1:LO];
            end
        end
        chk_cnt();
    endtask

    task automatic idle(input bit ictx, input bit itlb, input bit iline);
        fetch_valid = 0; fetch_va = {$urandom, $urandom};
        inv_ctx = ictx; inv_tlb = itlb; inv_line = iline;
        #1;
        chk("R11 no strobes while idle", 64'({tlb_req, tag_en}), 64'd0);
        @(posedge clk); @(negedge clk);
        inv_ctx = 0; inv_tlb = 0; inv_line = 0;
        if (ictx || itlb) begin m_pv = 0; m_lv = 0; end
        if (iline) m_lv = 0;
        chk("R11 no output after idle", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        chk("R1 fetch_ready", 64'(fetch_ready), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk_cnt();
        idle(0, 0, 0);                               // R11
        fetch(mk_va(0, 1, 5), 0, 0, 0, 2, 0);        // R1 first fetch misses
        fetch(mk_va(0, 1, 9), 0, 0, 0, 1, 0);        // R4 same line
        fetch(mk_va(0, 2, 3), 0, 0, 0, 1, 0);        // R3 other line
        for (int i = 0; i < 4; i++) fetch(mk_va(0, i, i * 7), 0, 0, 0, 1, 0); // R5 back-to-back
        fetch(mk_va(0, 3, 1), 0, 0, 1, 1, 0);        // R8 same-cycle line invalidate
        idle(0, 0, 1);                               // R8
        fetch(mk_va(0, 3, 2), 0, 0, 0, 1, 0);        // R8 page reuse, tag lookup
        fetch(mk_va(0, 3, 2), 0, 1, 0, 3, 0);        // R7 inv_tlb with fetch
        fetch(mk_va(0, 3, 2), 1, 0, 0, 1, 0);        // R7 inv_ctx with fetch
        fetch(mk_va(1, 0, 0), 0, 0, 0, 3, 1);        // R9 invalidate while waiting
        fetch(mk_va(1, 0, 4), 0, 0, 0, 1, 1);        // R9 must miss again; response coincides with inv
        fetch(mk_va(1, 0, 4), 0, 0, 0, 2, 0);        // R9 miss again, now kept
        for (int i = 0; i < 20; i++) fetch(mk_va(1, 0, i), 0, 0, 0, 1, 0); // R10 wrap
        idle(1, 0, 0);                               // R7 context switch alone
        fetch(mk_va(1, 0, 4), 0, 0, 0, 1, 0);        // R7 misses after it
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom_range(0, 15));
            if (r == 0) idle($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0);
            else fetch(mk_va(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 63))),
                       $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0, $urandom_range(0, 7) == 0,
                       int'($urandom_range(1, 3)), $urandom_range(0, 7) == 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule